// File: doc/BRIEF.md
# Interrupt Redirection Service Engine

This block turns activity on a set of interrupt request lines into delivery requests for a processor-side interrupt fabric. Each pin has a 64-bit routing entry. The entry selects the vector, the delivery mode, the destination and destination mode, the trigger type and a mask bit. A pending bit per pin records outstanding requests.

Edge pins latch a rising edge and drop it again once that edge has been dispatched. Level pins follow their line. After one delivery, a level pin is held off by a remote-acknowledge bit until an end-of-interrupt (EOI) notice carrying the matching vector arrives. A scheduler picks the lowest-numbered eligible pin and can dispatch one request per clock. For entries in external-interrupt mode, the vector is first fetched from an attached legacy interrupt controller.

Deliveries leave on a valid/ready stream. While `dlv_valid` is high and `dlv_ready` is low, the payload is held unchanged and nothing new is dispatched. A transfer completes on every clock edge where both are high, and the next pick is loaded on that same edge. The legacy fetch is a request level answered by a single-cycle response pulse. The entry write port, the lines and the EOI port are plain strobes that are taken every cycle.

Top module: `irq_route_engine`

## Requirements
- R1: After reset every entry is masked with remote-acknowledge clear, no pin is pending, and `dlv_valid` and `ext_req_valid` are low. Unmasking an entry with no line activity produces no delivery.
- R2: Entry layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, remote-acknowledge in bit 14 (not writable), trigger in bit 15 (1 = level), mask in bit 16, destination in bits 63:56. A rising edge on an unmasked edge pin produces exactly one delivery. That delivery carries the entry's destination, destination mode, delivery mode, vector and trigger bit.
- R3: A rising edge on an edge pin whose entry is masked is discarded. Unmasking the entry afterwards yields no delivery.
- R4: An asserted level pin is delivered once if its remote-acknowledge bit is clear. The delivery sets that bit, and no further delivery of the pin happens while the bit stays set.
- R5: An EOI clears remote-acknowledge on every entry whose bit is set and whose vector equals the EOI vector. A still-asserted, unmasked pin is then delivered again. An EOI with any other vector has no effect.
- R6: Deasserting a level line clears that pin's pending bit, so a later matching EOI produces no delivery.
- R7: When several pins are eligible, they are dispatched in ascending pin order, one per cycle while `dlv_ready` stays high.
- R8: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid` stays high and every payload field stays stable.
- R9: For delivery mode 3'b111, the engine raises `ext_req_valid` until an `ext_rsp_valid` pulse arrives. The delivered vector is the `ext_rsp_vector` captured with that pulse, and `dlv_valid` is never high together with `ext_req_valid`.
- R10: Line 0 drives pin 2, OR-ed with line 2. Pin 0 has no source. All other lines drive the pin of the same number.
- R11: An entry write keeps the pin's remote-acknowledge bit, unless the written trigger bit selects edge, in which case the bit is cleared.
- R12: A rising edge on an edge pin that lands on the same clock edge that dispatches that pin stays pending and causes a second delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_PINS | Interrupt request lines |
| rte_wr_en | input | 1 | Entry write strobe |
| rte_wr_pin | input | PIN_W | Entry index to write |
| rte_wr_data | input | 64 | New entry contents |
| eoi_valid | input | 1 | EOI notice strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_level | output | 1 | Trigger type, 1 = level |
| ext_req_valid | output | 1 | Vector fetch request to the legacy controller |
| ext_rsp_valid | input | 1 | Single-cycle response pulse from the legacy controller |
| ext_rsp_vector | input | 8 | Vector returned with the response |

## Verification
The dispatch of an edge pin, which clears its pending bit, and a fresh rising edge on the same pin, which sets it, can fall on the same clock edge. The bench provokes this by pulsing two edge pins while `dlv_ready` is held low, so the lower pin sits stalled at the output. It then re-raises the higher pin's line in the very cycle it releases `dlv_ready`. The case is judged at the stream: the higher pin must come out twice after the lower one, which shows that the new edge won over the clear.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int RTE_W     = 64;
  localparam int VEC_W     = 8;
  localparam int DEST_W    = 8;
  localparam int MODE_W    = 3;
  localparam int F_VEC_LO  = 0;
  localparam int F_MODE_LO = 8;
  localparam int F_DMODE   = 11;
  localparam int F_DSTAT   = 12;
  localparam int F_POL     = 13;
  localparam int F_RACK    = 14;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;
  localparam int F_DEST_LO = 56;

  typedef logic [RTE_W-1:0] rte_t;

  localparam rte_t RW_BITS  = ~((rte_t'(1) << F_RACK) | (rte_t'(1) << F_DSTAT));
  localparam rte_t RST_RTE  = rte_t'(1) << F_MASK;
  localparam logic [MODE_W-1:0] MODE_EXTINT = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
    logic              level;
  } dlv_t;

  function automatic dlv_t rte_fields(rte_t e);
    dlv_t d;
    d.dest  = e[F_DEST_LO +: DEST_W];
    d.dmode = e[F_DMODE];
    d.mode  = e[F_MODE_LO +: MODE_W];
    d.vec   = e[F_VEC_LO +: VEC_W];
    d.level = e[F_TRIG];
    return d;
  endfunction
endpackage

// File: rtl/irq_pin_map.sv
module irq_pin_map #(
  parameter int NUM_PINS = 24,
  parameter int SRC_LINE = 0,
  parameter int DST_PIN  = 2
) (
  input  logic [NUM_PINS-1:0] lines,
  output logic [NUM_PINS-1:0] pins
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == DST_PIN) begin : g_dst
      assign pins[p] = lines[p] | lines[SRC_LINE];
    end else if (p == SRC_LINE) begin : g_src
      assign pins[p] = 1'b0;
    end else begin : g_one
      assign pins[p] = lines[p];
    end
  end
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PIN_W-1:0]   wr_pin,
  input  rte_t               wr_data,
  input  logic               commit_en,
  input  logic [PIN_W-1:0]   commit_pin,
  input  logic               commit_level,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vec,
  output rte_t               tbl [NUM_PINS],
  output logic [NUM_PINS-1:0] ack
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    rte_t ent_r;
    logic ack_r;
    logic sel_wr, sel_cm, eoi_hit;

    assign sel_wr  = wr_en && (wr_pin == PIN_W'(p));
    assign sel_cm  = commit_en && commit_level && (commit_pin == PIN_W'(p));
    assign eoi_hit = eoi_valid && ack_r && (ent_r[F_VEC_LO +: VEC_W] == eoi_vec);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_r <= RST_RTE;
        ack_r <= 1'b0;
      end else begin
        if (sel_wr) ent_r <= wr_data & RW_BITS;
        if (sel_wr && !wr_data[F_TRIG]) ack_r <= 1'b0;
        else if (sel_cm)                ack_r <= 1'b1;
        else if (eoi_hit)               ack_r <= 1'b0;
      end
    end

    assign tbl[p] = ent_r;
    assign ack[p] = ack_r;
  end
endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic                commit_en,
  input  logic [PIN_W-1:0]    commit_pin,
  input  logic                commit_level,
  output logic [NUM_PINS-1:0] pend
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pend
    logic prev_r, pend_r, rise, clr;

    assign rise = pin_in[p] & ~prev_r;
    assign clr  = commit_en && !commit_level && (commit_pin == PIN_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_r <= 1'b0;
        pend_r <= 1'b0;
      end else begin
        prev_r <= pin_in[p];
        if (level_vec[p])                pend_r <= pin_in[p];
        else if (rise && !mask_vec[p])   pend_r <= 1'b1;
        else if (clr)                    pend_r <= 1'b0;
      end
    end

    assign pend[p] = pend_r;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] elig,
  input  rte_t                tbl [NUM_PINS],
  input  logic                dlv_ready,
  input  logic                ext_rsp_valid,
  input  logic [VEC_W-1:0]    ext_rsp_vec,
  output logic                commit_en,
  output logic [PIN_W-1:0]    commit_pin,
  output logic                commit_level,
  output logic                dlv_valid,
  output dlv_t                dlv,
  output logic                ext_req_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_SEND} st_e;

  st_e              st;
  dlv_t             cur;
  dlv_t             pick_f;
  logic             found, free, load;
  logic [PIN_W-1:0] pick_pin;

  always_comb begin
    found    = 1'b0;
    pick_pin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found    = 1'b1;
        pick_pin = PIN_W'(i);
      end
    end
  end

  assign pick_f = rte_fields(tbl[pick_pin]);
  assign free   = (st == ST_IDLE) || ((st == ST_SEND) && dlv_ready);
  assign load   = free && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cur <= '0;
    end else if (load) begin
      cur <= pick_f;
      st  <= (pick_f.mode == MODE_EXTINT) ? ST_EXT : ST_SEND;
    end else if ((st == ST_EXT) && ext_rsp_valid) begin
      cur.vec <= ext_rsp_vec;
      st      <= ST_SEND;
    end else if ((st == ST_SEND) && dlv_ready) begin
      st <= ST_IDLE;
    end
  end

  assign commit_en     = load;
  assign commit_pin    = pick_pin;
  assign commit_level  = pick_f.level;
  assign dlv_valid     = (st == ST_SEND);
  assign ext_req_valid = (st == ST_EXT);
  assign dlv           = cur;
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_lines,
  input  logic                rte_wr_en,
  input  logic [PIN_W-1:0]    rte_wr_pin,
  input  logic [63:0]         rte_wr_data,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [7:0]          dlv_dest,
  output logic                dlv_dest_mode,
  output logic [2:0]          dlv_mode,
  output logic [7:0]          dlv_vector,
  output logic                dlv_level,
  output logic                ext_req_valid,
  input  logic                ext_rsp_valid,
  input  logic [7:0]          ext_rsp_vector
);
  logic [NUM_PINS-1:0] pins, pend, ack_vec, level_vec, mask_vec, elig;
  rte_t                tbl [NUM_PINS];
  logic                commit_en, commit_level;
  logic [PIN_W-1:0]    commit_pin;
  dlv_t                dlv;

  irq_pin_map #(.NUM_PINS(NUM_PINS)) u_map (
    .lines (irq_lines),
    .pins  (pins)
  );

  irq_entry_table #(.NUM_PINS(NUM_PINS)) u_tbl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (rte_wr_en),
    .wr_pin       (rte_wr_pin),
    .wr_data      (rte_wr_data),
    .commit_en    (commit_en),
    .commit_pin   (commit_pin),
    .commit_level (commit_level),
    .eoi_valid    (eoi_valid),
    .eoi_vec      (eoi_vector),
    .tbl          (tbl),
    .ack          (ack_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_flags
    assign level_vec[p] = tbl[p][F_TRIG];
    assign mask_vec[p]  = tbl[p][F_MASK];
  end

  irq_pending_ctrl #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_in       (pins),
    .level_vec    (level_vec),
    .mask_vec     (mask_vec),
    .commit_en    (commit_en),
    .commit_pin   (commit_pin),
    .commit_level (commit_level),
    .pend         (pend)
  );

  assign elig = pend & ~mask_vec & (~level_vec | ~ack_vec);

  irq_dispatch #(.NUM_PINS(NUM_PINS)) u_disp (
    .clk           (clk),
    .rst_n         (rst_n),
    .elig          (elig),
    .tbl           (tbl),
    .dlv_ready     (dlv_ready),
    .ext_rsp_valid (ext_rsp_valid),
    .ext_rsp_vec   (ext_rsp_vector),
    .commit_en     (commit_en),
    .commit_pin    (commit_pin),
    .commit_level  (commit_level),
    .dlv_valid     (dlv_valid),
    .dlv           (dlv),
    .ext_req_valid (ext_req_valid)
  );

  assign dlv_dest      = dlv.dest;
  assign dlv_dest_mode = dlv.dmode;
  assign dlv_mode      = dlv.mode;
  assign dlv_vector    = dlv.vec;
  assign dlv_level     = dlv.level;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [7:0]          dlv_dest,
  input logic                dlv_dest_mode,
  input logic [2:0]          dlv_mode,
  input logic [7:0]          dlv_vector,
  input logic                dlv_level,
  input logic                ext_req_valid,
  input logic                ext_rsp_valid,
  input logic [7:0]          ext_rsp_vector,
  input logic                commit_en,
  input logic [PIN_W-1:0]    commit_pin,
  input logic                commit_level,
  input logic [NUM_PINS-1:0] ack_vec,
  input logic                rte_wr_en,
  input logic [PIN_W-1:0]    rte_wr_pin
);
  // R8
  dlv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid &&
      $stable({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_level}));

  // R9
  ext_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |-> !dlv_valid);

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid && !ext_rsp_valid |=> ext_req_valid);

  // R9
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid && ext_rsp_valid |=> dlv_valid && dlv_mode == 3'b111 &&
      dlv_vector == $past(ext_rsp_vector));

  // R4
  lvl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && commit_level |-> !ack_vec[commit_pin]);

  // R4
  lvl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && commit_level && !(rte_wr_en && rte_wr_pin == commit_pin)
      |=> ack_vec[$past(commit_pin)]);
endmodule

bind irq_route_engine irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dlv_valid      (dlv_valid),
  .dlv_ready      (dlv_ready),
  .dlv_dest       (dlv_dest),
  .dlv_dest_mode  (dlv_dest_mode),
  .dlv_mode       (dlv_mode),
  .dlv_vector     (dlv_vector),
  .dlv_level      (dlv_level),
  .ext_req_valid  (ext_req_valid),
  .ext_rsp_valid  (ext_rsp_valid),
  .ext_rsp_vector (ext_rsp_vector),
  .commit_en      (commit_en),
  .commit_pin     (commit_pin),
  .commit_level   (commit_level),
  .ack_vec        (ack_vec),
  .rte_wr_en      (rte_wr_en),
  .rte_wr_pin     (rte_wr_pin)
);

// File: tb/irq_route_engine_tb_top.sv
`timescale 1ns/1ps
module irq_route_engine_tb_top;
  localparam int NUM_PINS = 24;
  localparam int PIN_W    = 5;
  localparam int LOG_N    = 64;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NUM_PINS-1:0] irq_lines = '0;
  logic                rte_wr_en = 1'b0;
  logic [PIN_W-1:0]    rte_wr_pin = '0;
  logic [63:0]         rte_wr_data = '0;
  logic                eoi_valid = 1'b0;
  logic [7:0]          eoi_vector = '0;
  logic                dlv_valid, dlv_dest_mode, dlv_level, ext_req_valid;
  logic                dlv_ready = 1'b1;
  logic [7:0]          dlv_dest, dlv_vector;
  logic [2:0]          dlv_mode;
  logic                ext_rsp_valid = 1'b0;
  logic [7:0]          ext_rsp_vector = '0;
  logic [7:0]          ext_value = 8'h5A;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  logic [20:0] log_pack [LOG_N];
  int          log_cyc  [LOG_N];
  int          n_log = 0;

  always #2 clk = ~clk;

  irq_route_engine #(.NUM_PINS(NUM_PINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .rte_wr_en(rte_wr_en), .rte_wr_pin(rte_wr_pin), .rte_wr_data(rte_wr_data),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_dest(dlv_dest),
    .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode), .dlv_vector(dlv_vector),
    .dlv_level(dlv_level), .ext_req_valid(ext_req_valid),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_vector(ext_rsp_vector)
  );

  // Delivery monitor: a handshake seen at the falling edge completes on the next rising edge.
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n && dlv_valid && dlv_ready && n_log < LOG_N) begin
      log_pack[n_log] = {dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_level};
      log_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  // Legacy controller model: answers each request with a one-cycle pulse.
  initial forever begin
    @(posedge clk);
    #1;
    ext_rsp_valid  = rst_n && ext_req_valid && !ext_rsp_valid;
    ext_rsp_vector = ext_value;
  end

  function automatic logic [63:0] mk_rte(logic [7:0] vec, logic [2:0] mode, logic dm,
                                         logic lvl, logic msk, logic [7:0] dest);
    logic [63:0] r = '0;
    r[7:0]   = vec;
    r[10:8]  = mode;
    r[11]    = dm;
    r[15]    = lvl;
    r[16]    = msk;
    r[63:56] = dest;
    return r;
  endfunction

  function automatic logic [20:0] exp_pack(logic [7:0] vec, logic [2:0] mode, logic dm,
                                           logic lvl, logic [7:0] dest);
    return {dest, dm, mode, vec, lvl};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_n(int n);
    repeat (n) step();
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_rte(int pin, logic [63:0] data);
    step();
    rte_wr_en   = 1'b1;
    rte_wr_pin  = PIN_W'(pin);
    rte_wr_data = data;
    step();
    rte_wr_en   = 1'b0;
  endtask

  task automatic send_eoi(logic [7:0] v);
    step();
    eoi_valid  = 1'b1;
    eoi_vector = v;
    step();
    eoi_valid  = 1'b0;
  endtask

  task automatic pulse(logic [NUM_PINS-1:0] m);
    step();
    irq_lines = irq_lines | m;
    step();
    irq_lines = irq_lines & ~m;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d5e);
    wait_n(4);
    rst_n = 1'b1;
    step();
    // R1: quiet outputs after reset
    check("R1 dlv_valid", 64'(dlv_valid), 64'd0);
    check("R1 ext_req_valid", 64'(ext_req_valid), 64'd0);
    n_log = 0;
    write_rte(5, mk_rte(8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01));
    wait_n(6);
    check("R1 no pending after unmask", 64'(n_log), 64'd0);
    write_rte(5, mk_rte(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 8'h01));

    // R2: random edge entries carry their fields
    for (int it = 0; it < 10; it++) begin
      int p;
      logic [7:0] vec, dest;
      logic [2:0] mode;
      logic dm;
      p    = 3 + int'($urandom_range(20));
      vec  = 8'($urandom);
      dest = 8'($urandom);
      mode = 3'($urandom_range(6));
      dm   = 1'($urandom);
      write_rte(p, mk_rte(vec, mode, dm, 1'b0, 1'b0, dest));
      n_log = 0;
      pulse(NUM_PINS'(1) << p);
      wait_n(6);
      check("R2 edge count", 64'(n_log), 64'd1);
      check("R2 edge fields", 64'(log_pack[0]), 64'(exp_pack(vec, mode, dm, 1'b0, dest)));
      write_rte(p, mk_rte(vec, mode, dm, 1'b0, 1'b1, dest));
    end

    // R3: masked edge is discarded
    write_rte(7, mk_rte(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 8'h07));
    n_log = 0;
    pulse(NUM_PINS'(1) << 7);
    write_rte(7, mk_rte(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 8'h07));
    wait_n(6);
    check("R3 masked edge dropped", 64'(n_log), 64'd0);
    pulse(NUM_PINS'(1) << 7);
    wait_n(6);
    check("R3 unmasked edge taken", 64'(n_log), 64'd1);
    write_rte(7, mk_rte(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 8'h07));

    // R4 R5 R6: level pin with remote acknowledge
    write_rte(9, mk_rte(8'h49, 3'd1, 1'b1, 1'b1, 1'b0, 8'hC3));
    n_log = 0;
    step();
    irq_lines[9] = 1'b1;
    wait_n(8);
    check("R4 level single delivery", 64'(n_log), 64'd1);
    check("R4 level fields", 64'(log_pack[0]), 64'(exp_pack(8'h49, 3'd1, 1'b1, 1'b1, 8'hC3)));
    send_eoi(8'h50);
    wait_n(6);
    check("R5 foreign EOI ignored", 64'(n_log), 64'd1);
    send_eoi(8'h49);
    wait_n(6);
    check("R5 matching EOI redelivers", 64'(n_log), 64'd2);
    irq_lines[9] = 1'b0;
    wait_n(2);
    send_eoi(8'h49);
    wait_n(6);
    check("R6 deasserted level not redelivered", 64'(n_log), 64'd2);
    write_rte(9, mk_rte(8'h49, 3'd1, 1'b1, 1'b1, 1'b1, 8'hC3));

    // R7: ascending order, back to back
    write_rte(12, mk_rte(8'h12, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0C));
    write_rte(4,  mk_rte(8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 8'h04));
    write_rte(17, mk_rte(8'h17, 3'd0, 1'b0, 1'b0, 1'b0, 8'h11));
    n_log = 0;
    pulse((NUM_PINS'(1) << 12) | (NUM_PINS'(1) << 4) | (NUM_PINS'(1) << 17));
    wait_n(8);
    check("R7 count", 64'(n_log), 64'd3);
    check("R7 order", {40'd0, log_pack[0][8:1], log_pack[1][8:1], log_pack[2][8:1]},
          {40'd0, 8'h04, 8'h12, 8'h17});
    check("R7 one per cycle", 64'(log_cyc[2] - log_cyc[0]), 64'd2);

    // R8: back-pressure holds the payload
    n_log = 0;
    dlv_ready = 1'b0;
    pulse(NUM_PINS'(1) << 4);
    step();
    for (int k = 0; k < 3; k++) begin
      check("R8 held valid", 64'(dlv_valid), 64'd1);
      check("R8 held vector", 64'(dlv_vector), 64'h04);
      step();
    end
    dlv_ready = 1'b1;
    wait_n(4);
    check("R8 released once", 64'(n_log), 64'd1);

    // R9: vector fetched from the legacy controller
    ext_value = 8'($urandom);
    if (ext_value == 8'h11) ext_value = 8'hA5;
    write_rte(10, mk_rte(8'h11, 3'd7, 1'b0, 1'b0, 1'b0, 8'h22));
    n_log = 0;
    pulse(NUM_PINS'(1) << 10);
    wait_n(8);
    check("R9 ext count", 64'(n_log), 64'd1);
    check("R9 ext fields", 64'(log_pack[0]), 64'(exp_pack(ext_value, 3'd7, 1'b0, 1'b0, 8'h22)));
    write_rte(10, mk_rte(8'h11, 3'd7, 1'b0, 1'b0, 1'b1, 8'h22));

    // R10: line 0 lands on pin 2
    write_rte(2, mk_rte(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 8'h02));
    write_rte(0, mk_rte(8'h0A, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00));
    n_log = 0;
    pulse(NUM_PINS'(1));
    wait_n(6);
    check("R10 remap count", 64'(n_log), 64'd1);
    check("R10 remap vector", 64'(log_pack[0][8:1]), 64'h22);
    write_rte(2, mk_rte(8'h22, 3'd0, 1'b0, 1'b0, 1'b1, 8'h02));
    write_rte(0, mk_rte(8'h0A, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00));

    // R11: rewrite keeps acknowledge unless switched to edge
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b1, 1'b0, 8'h0E));
    n_log = 0;
    step();
    irq_lines[14] = 1'b1;
    wait_n(6);
    check("R11 first level delivery", 64'(n_log), 64'd1);
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b1, 1'b1, 8'h0E));
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b1, 1'b0, 8'h0E));
    wait_n(6);
    check("R11 level rewrite keeps ack", 64'(n_log), 64'd1);
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b0, 1'b1, 8'h0E));
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b1, 1'b0, 8'h0E));
    wait_n(6);
    check("R11 edge rewrite clears ack", 64'(n_log), 64'd2);
    irq_lines[14] = 1'b0;
    write_rte(14, mk_rte(8'h3E, 3'd0, 1'b0, 1'b1, 1'b1, 8'h0E));

    // R12: new edge on the dispatch edge of the same pin
    write_rte(3, mk_rte(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 8'h03));
    write_rte(6, mk_rte(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 8'h06));
    n_log = 0;
    dlv_ready = 1'b0;
    pulse((NUM_PINS'(1) << 3) | (NUM_PINS'(1) << 6));
    wait_n(3);
    irq_lines[6] = 1'b1;
    dlv_ready    = 1'b1;
    step();
    irq_lines[6] = 1'b0;
    wait_n(6);
    check("R12 count", 64'(n_log), 64'd3);
    check("R12 order", {40'd0, log_pack[0][8:1], log_pack[1][8:1], log_pack[2][8:1]},
          {40'd0, 8'h33, 8'h66, 8'h66});

    done = 1'b1;
    finish_run();
  end
endmodule